// File: doc/BRIEF.md
# Shared Scratch and FIFO Fill-Count Register Slot

This block fills one byte-wide address in a serial channel's register file. The same address serves two purposes. With the swap input low, it is an ordinary read/write scratch byte. With the swap input high, it becomes a read-only window onto the receive and transmit FIFO fill counts. In that state, host writes to the address load a small write-only source-select field instead of the scratch byte.

The source-select field picks what a read returns. It can return the receive count or the transmit count. In ping-pong mode, successive reads return the receive count and then the transmit count, repeating. Any load of the field restarts ping-pong at the receive side.

Read data is registered. The value returned is the one present at the read strobe, and it stays on the read-data port until the next read. A sleep input freezes the scratch contents.

Top module: `scratch_level_slot`

## Requirements
- R1: After reset the scratch byte is 0xFF, the source-select field (`mode_out`) is 2'b00, the read data is 0x00, and ping-pong starts on the receive side.
- R2: With `swap`=0, a selected write stores `wdata` in the scratch byte, and a selected read returns the scratch byte.
- R3: With `swap`=1, a selected write loads `wdata[1:0]` into the source-select field and leaves the scratch byte unchanged. The scratch byte reads back intact once `swap` returns to 0.
- R4: With `swap`=1, select code 2'b00 returns the receive count, 2'b01 returns the transmit count, and 2'b10 returns the receive count.
- R5: With `swap`=1 and select code 2'b11, selected reads return the receive count and the transmit count in alternation.
- R6: Every load of the source-select field re-arms ping-pong, so the next selected read returns the receive count.
- R7: Only a read strobe with `sel`=1 advances ping-pong. Idle cycles and reads with `sel`=0 leave the sequence where it was.
- R8: Bits 7:2 of a write to the source-select field are ignored: `mode_out` takes only `wdata[1:0]`.
- R9: While `sleep`=1, scratch writes are ignored and the scratch byte keeps its contents.
- R10: `rdata` updates on the clock edge that samples a selected read strobe, using the inputs present at that edge. It holds that value until the next selected read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Address select for this slot |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| rx_level | input | 8 | Receive FIFO fill count |
| tx_level | input | 8 | Transmit FIFO fill count |
| swap | input | 1 | 1 = address shows counts and writes load the source select |
| sleep | input | 1 | 1 = scratch byte frozen |
| mode_out | output | 2 | Current source-select field |

## Verification
All 256 scratch values are written and read back with `swap` low, so a stuck or swapped data bit in the scratch path shows up. Each select code is loaded with different junk in bits 7:2, using receive and transmit counts that differ. This separates the receive and transmit paths, confirms that the upper bits are dropped, and shows that the scratch byte survives the swapped writes. Ping-pong runs are broken by idle cycles, unselected reads and reloads of the field. Each break is checked to confirm it freezes or restarts the sequence as required, and the counts change between reads so that a stale sample is detected.

// File: rtl/slot_pkg.sv
package slot_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SRC_RX     = 2'b00,
      SRC_TX     = 2'b01,
      SRC_RX_ALT = 2'b10,
      SRC_PINGPONG = 2'b11
   } src_sel_e;
endpackage

// File: rtl/slot_scratch_reg.sv
module slot_scratch_reg #(
   parameter int          DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              sleep,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   logic upd;
   assign upd = wr_en && !sleep;

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= RESET_VAL;
      else if (upd) q <= d;
   end

   AST_SCRATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(q)); // R9
   AST_SCRATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sleep) |=> (q == $past(d))); // R2
endmodule

// File: rtl/slot_mode_ctrl.sv
module slot_mode_ctrl
   import slot_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] load_val,
   input  logic             rd_hit,
   input  logic             swap,
   output src_sel_e         mode,
   output logic             on_tx
);
   logic flip;
   assign flip = rd_hit && swap && (mode == SRC_PINGPONG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode  <= SRC_RX;
         on_tx <= 1'b0;
      end else if (load) begin
         mode  <= src_sel_e'(load_val);
         on_tx <= 1'b0;
      end else if (flip) begin
         on_tx <= ~on_tx;
      end
   end

   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mode == $past(load_val))); // R3
   AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !on_tx); // R6
   AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_hit && !load) |=> $stable(on_tx)); // R7
   AST_ALT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !load && swap && mode == SRC_PINGPONG) |=> (on_tx != $past(on_tx))); // R5
endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
   import slot_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  logic              swap,
   input  src_sel_e          mode,
   input  logic              on_tx,
   input  logic [DATA_W-1:0] scratch,
   input  logic [CNT_W-1:0]  rx_cnt,
   input  logic [CNT_W-1:0]  tx_cnt,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rx_ext, tx_ext, src;

   generate
      if (CNT_W == DATA_W) begin : g_full
         assign rx_ext = rx_cnt;
         assign tx_ext = tx_cnt;
      end else begin : g_pad
         assign rx_ext = {{(DATA_W-CNT_W){1'b0}}, rx_cnt};
         assign tx_ext = {{(DATA_W-CNT_W){1'b0}}, tx_cnt};
      end
   endgenerate

   always_comb begin
      if (!swap) src = scratch;
      else begin
         unique case (mode)
            SRC_TX:       src = tx_ext;
            SRC_PINGPONG: src = on_tx ? tx_ext : rx_ext;
            default:      src = rx_ext;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_hit) rdata <= src;
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> $stable(rdata)); // R10
   AST_SCRATCH_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !swap) |=> (rdata == $past(scratch))); // R2
endmodule

// File: rtl/scratch_level_slot.sv
module scratch_level_slot
   import slot_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter logic [DATA_W-1:0] SCRATCH_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [CNT_W-1:0]  rx_level,
   input  logic [CNT_W-1:0]  tx_level,
   input  logic              swap,
   input  logic              sleep,
   output logic [SEL_W-1:0]  mode_out
);
   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must not exceed DATA_W");
      end
      if (DATA_W < SEL_W) begin : g_bad_data
         $error("DATA_W too narrow for the select field");
      end
   endgenerate

   logic              wr_hit, rd_hit, scr_wr, mode_ld, on_tx;
   logic [DATA_W-1:0] scratch_q;
   src_sel_e          mode;

   assign wr_hit  = sel && wr;
   assign rd_hit  = sel && rd;
   assign scr_wr  = wr_hit && !swap;
   assign mode_ld = wr_hit && swap;

   slot_scratch_reg #(.DATA_W(DATA_W), .RESET_VAL(SCRATCH_RST)) i_scratch (
      .clk(clk), .rst_n(rst_n), .wr_en(scr_wr), .sleep(sleep),
      .d(wdata), .q(scratch_q)
   );

   slot_mode_ctrl i_mode (
      .clk(clk), .rst_n(rst_n), .load(mode_ld), .load_val(wdata[SEL_W-1:0]),
      .rd_hit(rd_hit), .swap(swap), .mode(mode), .on_tx(on_tx)
   );

   slot_read_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_mux (
      .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .swap(swap), .mode(mode),
      .on_tx(on_tx), .scratch(scratch_q), .rx_cnt(rx_level), .tx_cnt(tx_level),
      .rdata(rdata)
   );

   assign mode_out = mode;

   AST_SWAP_KEEPS_SCRATCH: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> $stable(scratch_q)); // R3
endmodule

// File: tb/test_scratch_level_slot.sv
module test_scratch_level_slot;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sel = 0, rd = 0, wr = 0, swap = 0, sleep = 0;
   logic [7:0] wdata = 0, rx_level = 0, tx_level = 0;
   logic [7:0] rdata;
   logic [1:0] mode_out;
   int         n_vec = 0, n_bad = 0;
   logic       done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scratch_level_slot i_scratch_level_slot (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .wdata(wdata),
      .rdata(rdata), .rx_level(rx_level), .tx_level(tx_level), .swap(swap),
      .sleep(sleep), .mode_out(mode_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] v);
      @(negedge clk); sel = 1; wr = 1; wdata = v;
      @(negedge clk); sel = 0; wr = 0;
   endtask

   // one selected read; returns rdata sampled after the capturing edge
   task automatic do_read(output logic [7:0] v);
      @(negedge clk); sel = 1; rd = 1;
      @(negedge clk); sel = 0; rd = 0; v = rdata;
   endtask

   task automatic set_levels(input logic [7:0] r, input logic [7:0] t);
      @(negedge clk); rx_level = r; tx_level = t;
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         n_bad++; n_vec++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 rdata", rdata, 8'h00);
      check("R1 mode", mode_out, 2'b00);
      do_read(v); check("R1 scratch reset", v, 8'hFF);

      // R2: full sweep of scratch values
      for (int i = 0; i < 256; i++) begin
         do_write(8'(i));
         do_read(v); check("R2 scratch", v, i);
      end

      // R10: hold between reads, idle cycles
      do_write(8'h5A); do_read(v);
      repeat (3) @(negedge clk);
      check("R10 hold", rdata, 8'h5A);

      // R3/R4/R8: each code with junk upper bits
      for (int m = 0; m < 3; m++) begin
         for (int j = 0; j < 4; j++) begin
            logic [7:0] junk;
            junk = 8'((j * 8'h44) | (j << 2)) & 8'hFC;
            swap = 1;
            do_write(junk | 8'(m));
            check("R8 mode_out", mode_out, m);
            set_levels(8'(17 + m*31 + j), 8'(200 - m*13 - j));
            do_read(v);
            check("R4 source", v, (m == 1) ? (200 - m*13 - j) : (17 + m*31 + j));
            @(negedge clk); swap = 0;
            do_read(v); check("R3 scratch intact", v, 8'h5A);
         end
      end

      // R5/R6/R7: ping-pong
      swap = 1;
      do_write(8'hF3);
      check("R8 mode_out pp", mode_out, 2'b11);
      for (int k = 0; k < 6; k++) begin
         set_levels(8'(10 + k), 8'(100 + k));
         do_read(v);
         check("R5 alternate", v, (k % 2 == 0) ? (10 + k) : (100 + k));
      end
      // after even count next is RX; insert idle and unselected reads
      repeat (4) @(negedge clk);
      @(negedge clk); rd = 1; sel = 0;
      @(negedge clk); rd = 0;
      set_levels(8'h21, 8'h42);
      do_read(v); check("R7 no advance", v, 8'h21);
      do_read(v); check("R5 tx", v, 8'h42);
      do_read(v); check("R5 rx", v, 8'h21);
      // now pending TX; reload re-arms
      do_write(8'h03);
      do_read(v); check("R6 rearm rx", v, 8'h21);
      do_write(8'h03);
      do_read(v); check("R6 rearm again", v, 8'h21);
      do_read(v); check("R6 then tx", v, 8'h42);

      // R10: value sampled at strobe edge
      @(negedge clk); sel = 1; rd = 1;
      @(posedge clk); #1 rx_level = 8'h99;
      @(negedge clk); sel = 0; rd = 0;
      check("R10 sampled", rdata, 8'h21);

      // R9: sleep freezes scratch
      @(negedge clk); swap = 0; sleep = 1;
      do_write(8'hC3);
      @(negedge clk); sleep = 0;
      do_read(v); check("R9 frozen", v, 8'h5A);
      do_write(8'hC3);
      do_read(v); check("R9 after wake", v, 8'hC3);

      // R1: reset again
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      check("R1 mode after reset", mode_out, 0);
      check("R1 rdata after reset", rdata, 0);
      do_read(v); check("R1 scratch after reset", v, 8'hFF);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule